// File: doc/BRIEF.md
# Serial NOR Flash Program and Erase Sequencer

This block sits on the host side of a single-bit SPI link to a serial NOR flash. It performs page programming and the three erase sizes: subsector, sector and whole device. A client presents one request with an operation kind, a 24-bit byte address and, for programming, a byte count. The block then runs the full device conversation by itself. It first sends a one-byte write-enable frame, then the command frame, and then polls the status register until the write-in-progress flag clears. It reports completion on a one-cycle `done` pulse, and `error` pulses with `done` when the request failed.

Program data is streamed. The block reads `wr_data` when it launches each data byte and pulses `data_take` on the following cycle, so the client can present the next byte. Requests that would leave one page, and requests with a zero or oversized count, are refused at once and cause no bus activity. The serial clock is a divided system clock. Chip select is held high for a minimum time between any two frames.

Top module: `spi_flash_pe_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done`, `error` and `data_take` are 0.
- R2: Every accepted request begins with a frame that holds the single byte 06h. Chip select is raised after that frame and before the command frame starts.
- R3: A page program (kind 0) sends one frame. The frame holds 02h, then address bits [23:16], [15:8] and [7:0], then exactly `req_len` data bytes in the order they were streamed. `data_take` pulses once for each data byte.
- R4: A subsector erase (kind 1) sends 20h and a sector erase (kind 2) sends D8h, each followed by the three address bytes from most to least significant. A whole-device erase (kind 3) sends only C7h.
- R5: After the command frame, the block repeats two-byte frames made of 05h and a filler byte 00h. The second byte is read back as the status. Polling continues while bit 0 of that status is 1. The first status with bit 0 equal to 0 ends the request with `done`=1 and `error`=0. The other status bits have no effect.
- R6: A page program with `req_len` equal to 0, `req_len` above 256, or `req_addr[7:0] + req_len` above 256 is refused. The cycle after the request, `done` and `error` are both 1, and chip select never falls. A request that ends exactly on the last byte of a page is accepted. For erase kinds, `req_len` is ignored.
- R7: The serial link uses SPI mode 0. SCK is low while chip select is high. Bytes go out MSB first. MOSI is stable while SCK is high. Every SCK high phase lasts `CLK_DIV/2` system clocks.
- R8: Chip select stays high for at least `CS_GAP` system clocks before every falling edge, including between successive status polls.
- R9: If `POLL_LIMIT` is nonzero and `POLL_LIMIT` consecutive status reads all show bit 0 set, the block stops polling and reports `done`=1 with `error`=1.
- R10: `busy` rises only in the cycle after an accepted request and falls when `done` pulses. `done` lasts exactly one cycle. `req_valid` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_kind | input | 2 | 0 page program, 1 subsector erase, 2 sector erase, 3 whole-device erase |
| req_addr | input | 24 | Flash byte address |
| req_len | input | LEN_W (9) | Program byte count, 1 to PAGE_BYTES |
| wr_data | input | 8 | Current program data byte |
| data_take | output | 1 | Pulses once for each program byte consumed |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Valid with done: refused or poll timeout |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions assume the client holds `req_valid` for a single cycle and keeps `wr_data` steady from one `data_take` pulse to the next. They also assume `spi_miso` changes only while SCK is low. The bench satisfies all three. It pulses requests at the falling clock edge and advances its data index only on `data_take`. Its flash model drives status bits on SCK falling edges. That model decodes every frame and answers polls from a busy countdown set per request. Idle status values carry unrelated bits set, which tests that only bit 0 matters.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    K_PP  = 2'd0,
    K_SSE = 2'd1,
    K_SE  = 2'd2,
    K_BE  = 2'd3
  } op_kind_t;

  typedef enum logic [1:0] {
    FR_WREN,
    FR_CMD,
    FR_POLL,
    FR_END
  } frame_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_GAP,
    S_XFER
  } seq_state_t;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_PP   = 8'h02;
  localparam logic [7:0] OPC_SSE  = 8'h20;
  localparam logic [7:0] OPC_SE   = 8'hD8;
  localparam logic [7:0] OPC_BE   = 8'hC7;
  localparam logic [7:0] OPC_RDSR = 8'h05;

endpackage

// File: rtl/fseq_req_check.sv
module fseq_req_check
  import flash_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  localparam int PG_W  = $clog2(PAGE_BYTES),
  localparam int LEN_W = $clog2(PAGE_BYTES + 1)
) (
  input  op_kind_t             kind,
  input  logic [PG_W-1:0]      addr_lo,
  input  logic [LEN_W-1:0]     len,
  output logic                 ok
);

  logic [LEN_W:0] end_off;

  always_comb begin
    end_off = {1'b0, (LEN_W)'(addr_lo)} + {1'b0, len};
    if (kind == K_PP)
      ok = (len != '0) && (end_off <= (LEN_W+1)'(PAGE_BYTES));
    else
      ok = 1'b1;
  end

endmodule

// File: rtl/fseq_spi_byte.sv
module fseq_spi_byte #(
  parameter int CLK_DIV = 4,
  localparam int HALF = CLK_DIV / 2,
  localparam int HC_W = $clog2(HALF + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic       rx_last
);

  logic [7:0]      sh;
  logic [2:0]      bitn;
  logic [HC_W-1:0] hcnt;
  logic            run;

  assign mosi = sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      bitn    <= '0;
      hcnt    <= '0;
      run     <= 1'b0;
      sck     <= 1'b0;
      done    <= 1'b0;
      rx_last <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        run  <= 1'b1;
        sh   <= tx;
        bitn <= '0;
        hcnt <= '0;
        sck  <= 1'b0;
      end else if (run) begin
        if (hcnt == HC_W'(HALF - 1)) begin
          hcnt <= '0;
          if (!sck) begin
            sck     <= 1'b1;
            rx_last <= miso;
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              run  <= 1'b0;
              done <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_flash_pe_seq.sv
module spi_flash_pe_seq
  import flash_seq_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int CS_GAP     = 4,
  parameter int POLL_LIMIT = 1000,
  parameter int PAGE_BYTES = 256,
  localparam int LEN_W = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  output logic             data_take,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);

  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int IDX_W = $clog2(PAGE_BYTES + 5);
  localparam int GC_W  = $clog2(CS_GAP + 1);
  localparam int PC_W  = $clog2(POLL_LIMIT + 2);

  seq_state_t       st;
  frame_t           cur_fr, nxt_fr;
  op_kind_t         kind_q;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] bidx, nidx, flen;
  logic [GC_W-1:0]  gcnt;
  logic [PC_W-1:0]  pcnt;
  logic             err_q, req_ok;
  logic             eng_start, eng_done, eng_rx;
  logic [7:0]       eng_tx;

  function automatic logic [7:0] pick_byte(frame_t fr, logic [IDX_W-1:0] i,
                                           op_kind_t k, logic [23:0] a,
                                           logic [7:0] d);
    logic [7:0] b;
    case (fr)
      FR_WREN: b = OPC_WREN;
      FR_POLL: b = (i == '0) ? OPC_RDSR : 8'h00;
      FR_CMD: begin
        if (i == '0) begin
          case (k)
            K_PP:    b = OPC_PP;
            K_SSE:   b = OPC_SSE;
            K_SE:    b = OPC_SE;
            default: b = OPC_BE;
          endcase
        end else if (i == IDX_W'(1)) b = a[23:16];
        else if (i == IDX_W'(2))     b = a[15:8];
        else if (i == IDX_W'(3))     b = a[7:0];
        else                         b = d;
      end
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  fseq_req_check #(.PAGE_BYTES(PAGE_BYTES)) u_chk_req (
    .kind    (op_kind_t'(req_kind)),
    .addr_lo (req_addr[PG_W-1:0]),
    .len     (req_len),
    .ok      (req_ok)
  );

  fseq_spi_byte #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (eng_start),
    .tx      (eng_tx),
    .miso    (spi_miso),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .done    (eng_done),
    .rx_last (eng_rx)
  );

  always_comb begin
    nidx = bidx + 1'b1;
    case (cur_fr)
      FR_POLL: flen = IDX_W'(2);
      FR_CMD: begin
        if (kind_q == K_BE)      flen = IDX_W'(1);
        else if (kind_q == K_PP) flen = IDX_W'(4) + IDX_W'(len_q);
        else                     flen = IDX_W'(4);
      end
      default: flen = IDX_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      cur_fr    <= FR_WREN;
      nxt_fr    <= FR_WREN;
      kind_q    <= K_PP;
      addr_q    <= '0;
      len_q     <= '0;
      bidx      <= '0;
      gcnt      <= '0;
      pcnt      <= '0;
      err_q     <= 1'b0;
      eng_start <= 1'b0;
      eng_tx    <= '0;
      data_take <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      spi_cs_n  <= 1'b1;
    end else begin
      done      <= 1'b0;
      error     <= 1'b0;
      eng_start <= 1'b0;
      data_take <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            if (req_ok) begin
              kind_q <= op_kind_t'(req_kind);
              addr_q <= req_addr;
              len_q  <= req_len;
              busy   <= 1'b1;
              nxt_fr <= FR_WREN;
              gcnt   <= '0;
              pcnt   <= '0;
              err_q  <= 1'b0;
              st     <= S_GAP;
            end else begin
              done  <= 1'b1;
              error <= 1'b1;
            end
          end
        end
        S_GAP: begin
          if (gcnt >= GC_W'(CS_GAP - 1)) begin
            if (nxt_fr == FR_END) begin
              done  <= 1'b1;
              error <= err_q;
              busy  <= 1'b0;
              st    <= S_IDLE;
            end else begin
              spi_cs_n  <= 1'b0;
              cur_fr    <= nxt_fr;
              bidx      <= '0;
              eng_start <= 1'b1;
              eng_tx    <= pick_byte(nxt_fr, '0, kind_q, addr_q, wr_data);
              st        <= S_XFER;
            end
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        S_XFER: begin
          if (eng_done) begin
            if (nidx < flen) begin
              bidx      <= nidx;
              eng_start <= 1'b1;
              eng_tx    <= pick_byte(cur_fr, nidx, kind_q, addr_q, wr_data);
              data_take <= (cur_fr == FR_CMD) && (nidx >= IDX_W'(4));
            end else begin
              spi_cs_n <= 1'b1;
              gcnt     <= '0;
              st       <= S_GAP;
              case (cur_fr)
                FR_WREN: nxt_fr <= FR_CMD;
                FR_CMD:  nxt_fr <= FR_POLL;
                default: begin
                  if (!eng_rx) begin
                    nxt_fr <= FR_END;
                  end else if ((POLL_LIMIT != 0) &&
                               (pcnt == PC_W'(POLL_LIMIT - 1))) begin
                    nxt_fr <= FR_END;
                    err_q  <= 1'b1;
                  end else begin
                    pcnt   <= pcnt + 1'b1;
                    nxt_fr <= FR_POLL;
                  end
                end
              endcase
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker #(
  parameter int CS_GAP = 4,
  localparam int HW = $clog2(CS_GAP + 2)
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic error,
  input logic spi_sck,
  input logic spi_cs_n,
  input logic spi_mosi
);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      hi_cnt <= '0;
    else if (spi_cs_n)
      hi_cnt <= (hi_cnt == HW'(CS_GAP + 1)) ? hi_cnt : hi_cnt + 1'b1;
    else
      hi_cnt <= '0;
  end

  assert_sck_idle_R7: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && spi_sck) |-> $stable(spi_mosi));

  assert_cs_gap_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_cs_n) |-> (hi_cnt >= HW'(CS_GAP)));

  assert_err_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    error |-> done);

  assert_reject_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (done && error && !$past(busy)) |-> (spi_cs_n && $past(spi_cs_n)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_start_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

endmodule

bind spi_flash_pe_seq fseq_checker #(.CS_GAP(CS_GAP)) u_fseq_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .error     (error),
  .spi_sck   (spi_sck),
  .spi_cs_n  (spi_cs_n),
  .spi_mosi  (spi_mosi)
);

// File: tb/sim_spi_flash_pe_seq.sv
module sim_spi_flash_pe_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 4;
  localparam int CS_GAP     = 3;
  localparam int POLL_LIMIT = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic [23:0] req_addr = '0;
  logic [8:0] req_len = '0;
  logic [7:0] wr_data;
  logic data_take, busy, done, error, spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] data_mem [256];
  int didx = 0, take_cnt = 0, done_cnt = 0, polls_left = 0;
  int bit_n = 0;
  logic [7:0] cur_b = '0;
  logic [7:0] frame_q[$], log_b[$], exp_b[$];
  int log_len[$], exp_len[$];
  int v_idle = 0, v_stab = 0, v_half = 0, v_gap = 0, hi_run = 0, cs_hi = 0;
  logic p_sck = 1'b0, p_mosi = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_pe_seq #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT))
  u0 (.clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data),
      .data_take(data_take), .busy(busy), .done(done), .error(error),
      .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso));

  assign wr_data = data_mem[didx & 255];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (data_take) begin take_cnt++; didx++; end
    if (done) done_cnt++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // flash model: decodes frames, answers status polls
  always @(negedge spi_cs_n) begin bit_n = 0; frame_q.delete(); end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    cur_b = {cur_b[6:0], spi_mosi};
    bit_n++;
    if (bit_n % 8 == 0) frame_q.push_back(cur_b);
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    if (frame_q.size() >= 1 && frame_q[0] == 8'h05 && bit_n >= 8 && bit_n < 16) begin
      logic [7:0] stat;
      stat = (polls_left > 0) ? 8'h03 : 8'h82;
      spi_miso = stat[15 - bit_n];
    end
  end
  always @(posedge spi_cs_n) if (!rst) begin
    foreach (frame_q[i]) log_b.push_back(frame_q[i]);
    log_len.push_back(frame_q.size());
    if (frame_q.size() > 0 && frame_q[0] == 8'h05 && polls_left > 0) polls_left--;
  end

  // per-clock bus-rule monitor (R7, R8)
  always @(negedge clk) if (!rst) begin
    if (spi_cs_n && spi_sck) v_idle++;
    if (spi_sck && p_sck && spi_mosi != p_mosi) v_stab++;
    if (spi_sck) hi_run++;
    else begin
      if (p_sck && hi_run != CLK_DIV/2) v_half++;
      hi_run = 0;
    end
    if (spi_cs_n) cs_hi++;
    else begin
      if (cs_hi != 0 && cs_hi < CS_GAP) v_gap++;
      cs_hi = 0;
    end
    p_sck = spi_sck; p_mosi = spi_mosi;
  end

  task automatic run_req(input logic [1:0] k, input logic [23:0] a, input int n,
                         input int bp, input bit exp_err, input bit quiet,
                         input bit poke, input string tag);
    int waited = 0, np;
    bit e;
    for (int i = 0; i < 256; i++) data_mem[i] = 8'((i * 37 + n + int'(a[7:0])) & 255);
    didx = 0; take_cnt = 0; done_cnt = 0; polls_left = bp;
    log_b.delete(); log_len.delete(); exp_b.delete(); exp_len.delete();
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_len = 9'(n);
    @(negedge clk);
    req_valid = 1'b0;
    if (quiet) begin
      chk(done === 1'b1, "R6", {tag, " done next cycle"}, int'(done), 1);
    end else begin
      chk(busy === 1'b1, "R10", {tag, " busy after accept"}, int'(busy), 1);
      while (done !== 1'b1 && waited < 60000) begin
        @(negedge clk); waited++;
        if (poke && waited == 40) begin
          req_valid = 1'b1; req_kind = 2'd3; req_len = 9'd0;
        end else req_valid = 1'b0;
      end
    end
    e = error;
    chk(done === 1'b1, "R10", {tag, " done seen"}, int'(done), 1);
    chk(e == exp_err, exp_err ? (quiet ? "R6" : "R9") : "R5", {tag, " error flag"},
        int'(e), int'(exp_err));
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R10", {tag, " done pulse ends idle"},
        int'({busy, done}), 0);
    chk(done_cnt == 1, "R10", {tag, " single done"}, done_cnt, 1);
    if (!quiet) begin
      exp_b.push_back(8'h06); exp_len.push_back(1);
      case (k)
        2'd3: begin exp_b.push_back(8'hC7); exp_len.push_back(1); end
        default: begin
          exp_b.push_back(k == 2'd0 ? 8'h02 : (k == 2'd1 ? 8'h20 : 8'hD8));
          exp_b.push_back(a[23:16]); exp_b.push_back(a[15:8]); exp_b.push_back(a[7:0]);
          if (k == 2'd0) for (int i = 0; i < n; i++) exp_b.push_back(data_mem[i]);
          exp_len.push_back(k == 2'd0 ? 4 + n : 4);
        end
      endcase
      np = exp_err ? POLL_LIMIT : bp + 1;
      for (int i = 0; i < np; i++) begin
        exp_b.push_back(8'h05); exp_b.push_back(8'h00); exp_len.push_back(2);
      end
    end
    chk(log_len.size() == exp_len.size(), "R2", {tag, " frame count"},
        log_len.size(), exp_len.size());
    begin
      int bad_len = 0, bad_b = 0;
      foreach (exp_len[i]) if (i < log_len.size() && log_len[i] != exp_len[i]) bad_len++;
      chk(bad_len == 0, "R5", {tag, " frame lengths"}, bad_len, 0);
      foreach (exp_b[i]) if (i >= log_b.size() || log_b[i] !== exp_b[i]) bad_b++;
      chk(bad_b == 0 && log_b.size() == exp_b.size(),
          (k == 2'd0) ? "R3" : "R4", {tag, " frame bytes"}, bad_b, 0);
    end
    chk(take_cnt == ((k == 2'd0 && !quiet) ? n : 0), "R3", {tag, " data_take count"},
        take_cnt, (k == 2'd0 && !quiet) ? n : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sck === 1'b0 && busy === 1'b0 && done === 1'b0
        && error === 1'b0 && data_take === 1'b0, "R1", "reset outputs",
        int'({spi_cs_n, spi_sck, busy, done, error, data_take}), 32);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(spi_cs_n === 1'b1 && busy === 1'b0, "R1", "idle after reset",
        int'({spi_cs_n, busy}), 2);
    run_req(2'd0, 24'h012300, 4,   2, 0, 0, 0, "R3 pp4");
    run_req(2'd0, 24'h000400, 256, 0, 0, 0, 0, "R6 pp full page");
    run_req(2'd0, 24'h0000F0, 16,  1, 0, 0, 0, "R6 pp ends at boundary");
    run_req(2'd1, 24'h0A1000, 0,   3, 0, 0, 0, "R4 subsector");
    run_req(2'd2, 24'h1F0000, 0,   1, 0, 0, 1, "R10 sector with poke");
    run_req(2'd3, 24'h123456, 0,   5, 0, 0, 0, "R4 bulk");
    run_req(2'd0, 24'h000010, 0,   0, 1, 1, 0, "R6 len zero");
    run_req(2'd0, 24'h000000, 257, 0, 1, 1, 0, "R6 len too big");
    run_req(2'd0, 24'h0000F1, 16,  0, 1, 1, 0, "R6 crosses page");
    run_req(2'd1, 24'h002000, 0,   50, 1, 0, 0, "R9 poll timeout");
    run_req(2'd2, 24'h030000, 0,   0, 0, 0, 0, "R5 after timeout");
    chk(v_idle == 0, "R7", "sck low while cs high", v_idle, 0);
    chk(v_stab == 0, "R7", "mosi stable while sck high", v_stab, 0);
    chk(v_half == 0, "R7", "sck high phase length", v_half, 0);
    chk(v_gap == 0, "R8", "cs high gap", v_gap, 0);
    finish_run();
  end
endmodule